// File: doc/BRIEF.md
# SM4 Iterative Block Cipher Core

This core enciphers a single 128-bit block with the SM4 cipher, computing one round per clock. Thirty-two 32-bit round keys are written beforehand into an internal key store through a plain write port. The caller raises `start` with a block on `block_in` while `ready` is high. Thirty-two cycles later the ciphertext appears on `block_out`, marked by a one-cycle `out_valid` pulse. Decryption uses the same core with the round keys written in reverse order.

The state is held as four 32-bit words that shift down by one place each round. The newest word enters at the top. Each round passes the XOR of three words and the round key through four byte S-boxes and a rotate-and-XOR diffusion map. The result is folded into the oldest word. Each S-box byte is produced by three steps: a nibble-table affine map into the AES field, the AES forward substitution, and a second nibble-table map back. The AES forward substitution is computed rather than stored.

Top module: `sm4_iter_core`

## Requirements
- R1: While reset is held low and in the first cycle after it, `ready` is 1, `out_valid` is 0 and `block_out` is all zeros.
- R2: `start` is taken only on a clock edge where `ready` is 1. From the following cycle `ready` stays 0 until the result is delivered.
- R3: `out_valid` is high for exactly one cycle, NUM_ROUNDS (32) clock edges after the accepting edge. `ready` returns to 1 in that same cycle.
- R4: A `start` pulse while `ready` is 0 has no effect: the running block's result, its timing and the count of `out_valid` pulses are unchanged.
- R5: Round n (n = 0..31, in increasing order) uses the key-store entry whose write address was n. Rewriting one entry changes the result of later blocks only through that round.
- R6: Byte 0 of a block is `block_in[127:120]`. Input word i is `block_in[127-32i -: 32]`, taken big-endian. After the last round, the four newest words are output newest first: `block_out[127:96]` is the word made by round 31, and `block_out[31:0]` is the word made by round 28.
- R7: Each round forms new = s0 ^ T(s1 ^ s2 ^ s3 ^ rk), where T applies the S-box to each byte and then x ^ rol(x,2) ^ rol(x,10) ^ rol(x,18) ^ rol(x,24). With the keys of key 0123456789ABCDEFFEDCBA9876543210, the plaintext of the same value encrypts to 681EDF34D206965E86B3E94F536E4246.
- R8: Each S-box byte is POST(AES(PRE(b))). A map M(b) is Mlo[b[3:0]] ^ Mhi[b[7:4]]. The tables are listed from index 0: PRE lo = 01 07 72 74 E4 E2 97 91 57 51 24 22 B2 B4 C1 C7; PRE hi = 00 A2 49 EB 09 AB 40 E2 12 B0 5B F9 1B B9 52 F0; POST lo = 34 08 9D A1 CE F2 67 5B 82 BE 2B 17 78 44 D1 ED; POST hi = 00 DC AF 73 DD 01 72 AE BF 63 10 CC 62 BE CD 11. AES(b) is the inverse of b in GF(2^8) modulo x^8+x^4+x^3+x+1 (with 0 mapped to 0), followed by the affine step s[i] = v[i]^v[i+4]^v[i+5]^v[i+6]^v[i+7]^0x63[i], indices taken mod 8.
- R9: After delivery, `block_out` holds its value until the next accepted `start`. Key-store writes do not alter it.
- R10: A `start` given in the same cycle as `out_valid` is accepted, so blocks can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key_we | input | 1 | Key-store write enable |
| key_addr | input | KEY_AW (5) | Key-store entry, equal to the round index |
| key_wdata | input | 32 | Round key to store |
| start | input | 1 | Request to begin a block |
| ready | output | 1 | Core idle; a start is taken this cycle |
| block_in | input | 128 | Plaintext block, byte 0 in the top bits |
| out_valid | output | 1 | One-cycle strobe marking a finished block |
| block_out | output | 128 | Ciphertext block, byte 0 in the top bits |

## Verification
The hardest case to reach is a `start` arriving at the wrong moment. One variant is a pulse in the middle of a run, which must leave both the result and the pulse count untouched. The other is a pulse exactly in the `out_valid` cycle, which must begin a new block at once. The bench places the middle-of-run pulse at a fixed cycle offset inside a run. It makes every run after the first begin in the delivery cycle of the one before, so the back-to-back path is taken on almost every block. The S-box and round arithmetic are covered by a sweep over all 128 single-bit plaintexts and several key sets. Each result is compared with a reference that builds the AES substitution by searching for field inverses rather than reading any table.

// File: rtl/sm4_core_pkg.sv
`timescale 1ns/1ps
package sm4_core_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int BLOCK_W = WORD_W * LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [15:0][BYTE_W-1:0] nib_tab_t;

  // Nibble tables, element 0 in the lowest byte.
  localparam nib_tab_t PRE_LO  = 128'hC7C1B4B222245157_9197E2E474720701;
  localparam nib_tab_t PRE_HI  = 128'hF052B91BF95BB012_E240AB09EB49A200;
  localparam nib_tab_t POST_LO = 128'hEDD14478172BBE82_5B67F2CEA19D0834;
  localparam nib_tab_t POST_HI = 128'h11CDBE62CC1063BF_AE7201DD73AFDC00;

  function automatic logic [7:0] nib_map(input nib_tab_t lo, input nib_tab_t hi,
                                         input logic [7:0] b);
    return lo[b[3:0]] ^ hi[b[7:4]];
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring; yields 0 for 0.
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] aes_fwd_sbox(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rol8(v, 1) ^ rol8(v, 2) ^ rol8(v, 3) ^ rol8(v, 4) ^ 8'h63;
  endfunction

  function automatic word_t lin_mix(input word_t x);
    return x ^ {x[29:0], x[31:30]} ^ {x[21:0], x[31:22]}
             ^ {x[13:0], x[31:14]} ^ {x[7:0], x[31:8]};
  endfunction
endpackage

// File: rtl/sm4_sbox_byte.sv
`timescale 1ns/1ps
module sm4_sbox_byte
  import sm4_core_pkg::*;
(
  input  logic [BYTE_W-1:0] in_b,
  output logic [BYTE_W-1:0] out_b
);
  logic [BYTE_W-1:0] to_aes;
  logic [BYTE_W-1:0] aes_out;

  assign to_aes  = nib_map(PRE_LO, PRE_HI, in_b);
  assign aes_out = aes_fwd_sbox(to_aes);
  assign out_b   = nib_map(POST_LO, POST_HI, aes_out);
endmodule

// File: rtl/sm4_round_fn.sv
`timescale 1ns/1ps
module sm4_round_fn
  import sm4_core_pkg::*;
(
  input  word_t s0,
  input  word_t s1,
  input  word_t s2,
  input  word_t s3,
  input  word_t rk,
  output word_t s_next
);
  word_t mix;
  word_t subst;

  assign mix = s1 ^ s2 ^ s3 ^ rk;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sm4_sbox_byte u_sbox (
      .in_b (mix[BYTE_W*g +: BYTE_W]),
      .out_b(subst[BYTE_W*g +: BYTE_W])
    );
  end

  assign s_next = s0 ^ lin_mix(subst);
endmodule

// File: rtl/sm4_rk_store.sv
`timescale 1ns/1ps
module sm4_rk_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sm4_iter_core.sv
`timescale 1ns/1ps
module sm4_iter_core
  import sm4_core_pkg::*;
#(
  parameter int NUM_ROUNDS = 32,
  parameter int KEY_AW     = $clog2(NUM_ROUNDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_we,
  input  logic [KEY_AW-1:0]  key_addr,
  input  logic [WORD_W-1:0]  key_wdata,
  input  logic               start,
  output logic               ready,
  input  logic [BLOCK_W-1:0] block_in,
  output logic               out_valid,
  output logic [BLOCK_W-1:0] block_out
);
  localparam int CNT_W = KEY_AW;

  word_t              st_q [LANES];
  logic               busy_q;
  logic               vld_q;
  logic [CNT_W-1:0]   rnd_q;
  word_t              round_key;
  word_t              new_word;

  // Named events shared with the checker.
  logic accept;
  logic last_round;

  assign accept     = start & ~busy_q;
  assign last_round = busy_q & (rnd_q == CNT_W'(NUM_ROUNDS - 1));

  sm4_rk_store #(
    .DEPTH(NUM_ROUNDS),
    .WIDTH(WORD_W),
    .AW   (KEY_AW)
  ) u_rk_store (
    .clk    (clk),
    .wr_en  (key_we),
    .wr_addr(key_addr),
    .wr_data(key_wdata),
    .rd_addr(rnd_q),
    .rd_data(round_key)
  );

  sm4_round_fn u_round (
    .s0    (st_q[0]),
    .s1    (st_q[1]),
    .s2    (st_q[2]),
    .s3    (st_q[3]),
    .rk    (round_key),
    .s_next(new_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) st_q[i] <= '0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      rnd_q  <= '0;
    end else begin
      vld_q <= last_round;
      if (accept) begin
        for (int i = 0; i < LANES; i++)
          st_q[i] <= block_in[BLOCK_W-1-WORD_W*i -: WORD_W];
        rnd_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        for (int i = 0; i < LANES-1; i++) st_q[i] <= st_q[i+1];
        st_q[LANES-1] <= new_word;
        rnd_q <= rnd_q + CNT_W'(1);
        if (last_round) busy_q <= 1'b0;
      end
    end
  end

  assign ready     = ~busy_q;
  assign out_valid = vld_q;

  // Newest word lands in the top bits.
  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign block_out[WORD_W*g +: WORD_W] = st_q[g];
  end
endmodule

// File: rtl/sm4_iter_core_chk.sv
`timescale 1ns/1ps
module sm4_iter_core_chk #(
  parameter int NUM_ROUNDS = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         out_valid,
  input logic [127:0] block_out,
  input logic         accept,
  input logic         last_round
);
  localparam int GW = $clog2(NUM_ROUNDS + 1);

  logic          run_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      gap_q <= '0;
    end else if (accept) begin
      run_q <= 1'b1;
      gap_q <= '0;
    end else if (run_q) begin
      if (gap_q == GW'(NUM_ROUNDS)) run_q <= 1'b0;
      else gap_q <= gap_q + GW'(1);
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  a_r3_valid_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_q && gap_q == GW'(NUM_ROUNDS)));

  a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> out_valid);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r3_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ready);

  a_r4_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && gap_q < GW'(NUM_ROUNDS)) |-> !ready);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(block_out));
endmodule

bind sm4_iter_core sm4_iter_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ready     (ready),
  .out_valid (out_valid),
  .block_out (block_out),
  .accept    (accept),
  .last_round(last_round)
);

// File: tb/test_sm4_iter_core.sv
`timescale 1ns/1ps
module test_sm4_iter_core;
  localparam int NR = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_we = 1'b0;
  logic [4:0]   key_addr = '0;
  logic [31:0]  key_wdata = '0;
  logic         start = 1'b0;
  logic         ready;
  logic [127:0] block_in = '0;
  logic         out_valid;
  logic [127:0] block_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sm4_iter_core i_sm4_iter_core (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .start(start), .ready(ready), .block_in(block_in),
    .out_valid(out_valid), .block_out(block_out)
  );

  // Reference tables, built from R8 arithmetic.
  logic [7:0]  aes_tab [256];
  logic [7:0]  sm_tab  [256];
  logic [31:0] rk_ref  [NR];
  logic [7:0] plo [16] = '{8'h01,8'h07,8'h72,8'h74,8'hE4,8'hE2,8'h97,8'h91,
                           8'h57,8'h51,8'h24,8'h22,8'hB2,8'hB4,8'hC1,8'hC7};
  logic [7:0] phi [16] = '{8'h00,8'hA2,8'h49,8'hEB,8'h09,8'hAB,8'h40,8'hE2,
                           8'h12,8'hB0,8'h5B,8'hF9,8'h1B,8'hB9,8'h52,8'hF0};
  logic [7:0] qlo [16] = '{8'h34,8'h08,8'h9D,8'hA1,8'hCE,8'hF2,8'h67,8'h5B,
                           8'h82,8'hBE,8'h2B,8'h17,8'h78,8'h44,8'hD1,8'hED};
  logic [7:0] qhi [16] = '{8'h00,8'hDC,8'hAF,8'h73,8'hDD,8'h01,8'h72,8'hAE,
                           8'hBF,8'h63,8'h10,8'hCC,8'h62,8'hBE,8'hCD,8'h11};

  function automatic logic [7:0] tb_gmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'(9'h11B) << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] tb_aes(input logic [7:0] a);
    logic [7:0] v;
    logic [7:0] s;
    v = 8'h00;
    for (int y = 1; y < 256; y++) if (tb_gmul(a, 8'(y)) == 8'h01) v = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
    return s;
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] tau(input logic [31:0] x);
    return {sm_tab[x[31:24]], sm_tab[x[23:16]], sm_tab[x[15:8]], sm_tab[x[7:0]]};
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] blk);
    logic [31:0] w [4];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = blk[127-32*i -: 32];
    for (int r = 0; r < NR; r++) begin
      t = tau(w[1] ^ w[2] ^ w[3] ^ rk_ref[r]);
      t = w[0] ^ t ^ rotl(t, 2) ^ rotl(t, 10) ^ rotl(t, 18) ^ rotl(t, 24);
      w[0] = w[1]; w[1] = w[2]; w[2] = w[3]; w[3] = t;
    end
    return {w[3], w[2], w[1], w[0]};
  endfunction

  task automatic key_schedule(input logic [127:0] mk);
    logic [31:0] fk [4] = '{32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC};
    logic [31:0] k [4];
    logic [31:0] ck;
    logic [31:0] t;
    for (int i = 0; i < 4; i++) k[i] = mk[127-32*i -: 32] ^ fk[i];
    for (int i = 0; i < NR; i++) begin
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      t = tau(k[1] ^ k[2] ^ k[3] ^ ck);
      t = k[0] ^ t ^ rotl(t, 13) ^ rotl(t, 23);
      rk_ref[i] = t;
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = t;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // All tasks begin and end just after a falling edge.
  task automatic write_key(input int a, input logic [31:0] d);
    key_we = 1'b1; key_addr = 5'(a); key_wdata = d;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic load_all_keys();
    for (int i = 0; i < NR; i++) write_key(i, rk_ref[i]);
  endtask

  task automatic launch(input logic [127:0] blk);
    start = 1'b1; block_in = blk;
    @(negedge clk);
    start = 1'b0;
  endtask

  // inj_at > 0 pulses start with a different block that many cycles into the run.
  task automatic finish_run(input logic [127:0] exp, input string req, input int inj_at);
    bit bad;
    bad = 1'b0;
    for (int k = 1; k <= NR; k++) begin
      if (out_valid || ready) bad = 1'b1;
      if (k == inj_at) begin start = 1'b1; block_in = ~block_in; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(!bad && out_valid && ready, "R2/R3 timing", {out_valid, ready, bad},
          {1'b1, 1'b1, 1'b0});
    check(block_out == exp, req, block_out, exp);
  endtask

  task automatic run_block(input logic [127:0] blk, input string req);
    launch(blk);
    finish_run(ref_enc(blk), req, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    logic [127:0] prev;
    for (int a = 0; a < 256; a++) aes_tab[a] = tb_aes(8'(a));
    for (int b = 0; b < 256; b++) begin
      logic [7:0] u;
      u = aes_tab[plo[b%16] ^ phi[b/16]];
      sm_tab[b] = qlo[u[3:0]] ^ qhi[u[7:4]];
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready", 128'(ready), 128'd1);
    check(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'd0);
    check(block_out == '0, "R1 block_out", block_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !out_valid && block_out == '0, "R1 after release",
          {out_valid, ready}, 128'd1);

    // R7: published vector
    key_schedule(128'h0123456789ABCDEFFEDCBA9876543210);
    load_all_keys();
    launch(128'h0123456789ABCDEFFEDCBA9876543210);
    finish_run(128'h681EDF34D206965E86B3E94F536E4246, "R7 vector", 0);

    // R9: output holds through idle and key writes
    held = block_out;
    @(negedge clk);
    check(!out_valid && ready, "R3 single pulse", {out_valid, ready}, 128'd1);
    write_key(7, ~rk_ref[7]);
    repeat (3) @(negedge clk);
    check(block_out == held, "R9 hold", block_out, held);
    write_key(7, rk_ref[7]);

    // R6: byte order, byte 0 at the top
    run_block(128'h000102030405060708090A0B0C0D0E0F, "R6 byte order");
    run_block('0, "R6 zero block");
    run_block('1, "R6 ones block");

    // R8/R7: walking single-bit sweep, runs chained back to back (R10)
    for (int b = 0; b < 128; b++) run_block(128'd1 << b, "R8 walking bit");

    // R4: start pulse in the middle of a run is ignored
    launch(128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D);
    finish_run(ref_enc(128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D), "R4 mid-run start", 10);
    @(negedge clk);
    check(!out_valid && ready, "R4 no extra pulse", {out_valid, ready}, 128'd1);

    // R10: start given exactly in the valid cycle
    launch(128'h11111111_22222222_33333333_44444444);
    finish_run(ref_enc(128'h11111111_22222222_33333333_44444444), "R10 first", 0);
    launch(128'h55555555_66666666_77777777_88888888);
    finish_run(ref_enc(128'h55555555_66666666_77777777_88888888), "R10 back to back", 0);

    // R5: a second key set, then single-entry rewrites at both ends
    for (int i = 0; i < NR; i++) rk_ref[i] = 32'h9E3779B9 * (i + 1);
    load_all_keys();
    for (int j = 0; j < 6; j++)
      run_block({4{32'h0F1E2D3C ^ (32'h01010101 * j)}}, "R5 key set two");
    prev = block_out;
    rk_ref[31] = rk_ref[31] ^ 32'h0000_0100;
    write_key(31, rk_ref[31]);
    run_block({4{32'h0F1E2D3C ^ 32'h05050505}}, "R5 last entry");
    check(block_out != prev, "R5 last entry used", block_out, ~prev);
    rk_ref[0] = rk_ref[0] ^ 32'h8000_0001;
    write_key(0, rk_ref[0]);
    run_block(128'h0123456789ABCDEFFEDCBA9876543210, "R5 first entry");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule